// File: doc/BRIEF.md
# Indexed Semaphore Bank with Dual Command Ports

This block keeps a bank of small counting semaphores and carries out one packed
32-bit command per port. Each port uses a valid/ready handshake. A command
completes in the cycle where valid and ready are both high. A command that
changes a semaphore updates it at that clock edge, and the new value is visible
from the next cycle.

Some commands wait for a condition on the semaphore: an exact value, a lower
bound, or a nonzero value followed by a take. Such a command holds ready low
until its condition holds, and the condition is tested again every cycle. While
one port stalls, the other port keeps working on the bank, which is how one
agent releases another.

Two command ports are provided. Port 0 has fixed priority over port 1. The
caller places the pre-sync or post-sync marker and handles fences; the block
only reports the marker back.

Top module: `sem_bank_exec`

## Requirements
- R1: After reset every semaphore holds zero.
- R2: A command whose bit 31 is 0 is accepted in the cycle it is presented and changes nothing.
- R3: Bits [20:16] select the semaphore and bits [11:0] give the operand. Opcode bits [26:24] value 0 does nothing, 1 loads the operand, 2 adds one and 3 subtracts one. Each of these is accepted at once.
- R4: Adding one to 4095 gives 0, and subtracting one from 0 gives 4095.
- R5: Opcode 4 keeps ready low until the selected semaphore equals the operand, then completes without a change.
- R6: Opcode 5 keeps ready low until the selected semaphore is at least the operand, then completes without a change.
- R7: Opcode 6 keeps ready low while the semaphore is zero. Once it is nonzero, it is accepted and lowers the semaphore by one at that same edge.
- R8: Opcode 7 is accepted at once and changes nothing. The port's err output is high in the accept cycle and low for every other accepted command.
- R9: The port's presync output is high while valid is high, bit 31 is 1 and bit 22 is 1.
- R10: When port 0 completes a command on the same semaphore that port 1 presents, port 1's ready stays low in that cycle. Commands on different semaphores complete together.
- R11: A stalled wait tests its condition again every cycle, and it completes once the other port has changed the semaphore.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_valid | input | 1 | Port 0 command present |
| p0_cmd | input | 32 | Port 0 command word |
| p0_ready | output | 1 | Port 0 command completes this cycle |
| p0_presync | output | 1 | Port 0 pre-sync marker |
| p0_err | output | 1 | Port 0 reserved opcode accepted |
| p1_valid | input | 1 | Port 1 command present |
| p1_cmd | input | 32 | Port 1 command word |
| p1_ready | output | 1 | Port 1 command completes this cycle |
| p1_presync | output | 1 | Port 1 pre-sync marker |
| p1_err | output | 1 | Port 1 reserved opcode accepted |

## Verification
The bench builds the block with its defaults: 32 semaphores of 12 bits. With these values the top index 31 can be selected directly. A single load of 4095 reaches the wrap point, so both wrap directions take only a few commands. The two ports let one port stall on a wait or a take while the other port releases it, and let both ports target one semaphore in the same cycle.

// File: rtl/sem_pkg.sv
package sem_pkg;
    localparam int CMD_W   = 32;
    localparam int EN_BIT  = 31;
    localparam int OP_LSB  = 24;
    localparam int OP_W    = 3;
    localparam int PRE_BIT = 22;
    localparam int IDX_LSB = 16;
    localparam int IDX_W   = 5;
    localparam int ARG_LSB = 0;
    localparam int ARG_W   = 12;
    localparam int NPORT   = 2;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 3'd0,
        OP_LOAD    = 3'd1,
        OP_INC     = 3'd2,
        OP_DEC     = 3'd3,
        OP_WAIT_EQ = 3'd4,
        OP_WAIT_GE = 3'd5,
        OP_TAKE    = 3'd6,
        OP_RSVD    = 3'd7
    } sem_op_e;

    typedef struct packed {
        logic             en;
        sem_op_e          op;
        logic             presync;
        logic [IDX_W-1:0] idx;
        logic [ARG_W-1:0] arg;
    } sem_cmd_t;

    function automatic sem_cmd_t unpack_cmd(input logic [CMD_W-1:0] w);
        sem_cmd_t c;
        c.en      = w[EN_BIT];
        c.op      = sem_op_e'(w[OP_LSB +: OP_W]);
        c.presync = w[PRE_BIT];
        c.idx     = w[IDX_LSB +: IDX_W];
        c.arg     = w[ARG_LSB +: ARG_W];
        return c;
    endfunction
endpackage

// File: rtl/sem_eval.sv
module sem_eval
    import sem_pkg::*;
#(
    parameter int VAL_W = 12
) (
    input  sem_cmd_t         cmd,
    input  logic [VAL_W-1:0] cur,
    output logic             cond_ok,
    output logic             wr_en,
    output logic [VAL_W-1:0] wr_val,
    output logic             rsvd
);
    localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

    logic [VAL_W-1:0] operand;
    assign operand = VAL_W'(cmd.arg);

    always_comb begin
        cond_ok = 1'b1;
        wr_en   = 1'b0;
        wr_val  = cur;
        rsvd    = 1'b0;
        if (cmd.en) begin
            unique case (cmd.op)
                OP_NOP:     ;
                OP_LOAD:    begin wr_en = 1'b1; wr_val = operand;   end
                OP_INC:     begin wr_en = 1'b1; wr_val = cur + ONE; end
                OP_DEC:     begin wr_en = 1'b1; wr_val = cur - ONE; end
                OP_WAIT_EQ: cond_ok = (cur == operand);
                OP_WAIT_GE: cond_ok = (cur >= operand);
                OP_TAKE: begin
                    cond_ok = (cur != '0);
                    wr_en   = 1'b1;
                    wr_val  = cur - ONE;
                end
                OP_RSVD:    rsvd = 1'b1;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/sem_arbiter.sv
module sem_arbiter #(
    parameter int NPORT = 2,
    parameter int IDX_W = 5
) (
    input  logic [NPORT-1:0]            go,
    input  logic [NPORT-1:0][IDX_W-1:0] idx,
    output logic [NPORT-1:0]            grant
);
    for (genvar k = 0; k < NPORT; k++) begin : g_port
        always_comb begin
            grant[k] = 1'b1;
            for (int j = 0; j < k; j++) begin
                if (go[j] && (idx[j] == idx[k])) grant[k] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/sem_store.sv
module sem_store #(
    parameter int NUM_SEM = 32,
    parameter int VAL_W   = 12,
    parameter int NPORT   = 2,
    parameter int IDX_W   = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NPORT-1:0][IDX_W-1:0] rd_idx,
    output logic [NPORT-1:0][VAL_W-1:0] rd_val,
    input  logic [NPORT-1:0]            we,
    input  logic [NPORT-1:0][IDX_W-1:0] wr_idx,
    input  logic [NPORT-1:0][VAL_W-1:0] wr_val
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_SEM);

    logic [NUM_SEM-1:0][VAL_W-1:0] bank;

    for (genvar k = 0; k < NPORT; k++) begin : g_rd
        assign rd_val[k] = ({1'b0, rd_idx[k]} < LIMIT) ? bank[rd_idx[k]] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= '0;
        end else begin
            for (int k = NPORT - 1; k >= 0; k--) begin
                if (we[k] && ({1'b0, wr_idx[k]} < LIMIT)) bank[wr_idx[k]] <= wr_val[k];
            end
        end
    end
endmodule

// File: rtl/sem_bank_exec.sv
module sem_bank_exec
    import sem_pkg::*;
#(
    parameter int NUM_SEM = 32,
    parameter int VAL_W   = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        p0_valid,
    input  logic [31:0] p0_cmd,
    output logic        p0_ready,
    output logic        p0_presync,
    output logic        p0_err,
    input  logic        p1_valid,
    input  logic [31:0] p1_cmd,
    output logic        p1_ready,
    output logic        p1_presync,
    output logic        p1_err
);
    logic     [NPORT-1:0]            valid_a, ready_a, pre_a, err_a;
    logic     [NPORT-1:0][CMD_W-1:0] word_a;
    sem_cmd_t                        cmd_a [NPORT];
    logic     [NPORT-1:0][IDX_W-1:0] idx_a;
    logic     [NPORT-1:0][VAL_W-1:0] cur_a, nxt_a;
    logic     [NPORT-1:0]            ok_a, upd_a, rsvd_a, go_a, grant_a, we_a;

    assign valid_a = {p1_valid, p0_valid};
    assign word_a  = {p1_cmd, p0_cmd};

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        assign cmd_a[g] = unpack_cmd(word_a[g]);
        assign idx_a[g] = cmd_a[g].idx;

        sem_eval #(.VAL_W(VAL_W)) u_eval (
            .cmd     (cmd_a[g]),
            .cur     (cur_a[g]),
            .cond_ok (ok_a[g]),
            .wr_en   (upd_a[g]),
            .wr_val  (nxt_a[g]),
            .rsvd    (rsvd_a[g])
        );

        assign go_a[g]    = valid_a[g] & cmd_a[g].en & ok_a[g];
        assign ready_a[g] = ~cmd_a[g].en | (ok_a[g] & grant_a[g]);
        assign we_a[g]    = valid_a[g] & ready_a[g] & upd_a[g];
        assign err_a[g]   = valid_a[g] & ready_a[g] & rsvd_a[g];
        assign pre_a[g]   = valid_a[g] & cmd_a[g].en & cmd_a[g].presync;
    end

    sem_arbiter #(.NPORT(NPORT), .IDX_W(IDX_W)) u_arb (
        .go    (go_a),
        .idx   (idx_a),
        .grant (grant_a)
    );

    sem_store #(.NUM_SEM(NUM_SEM), .VAL_W(VAL_W), .NPORT(NPORT), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (idx_a),
        .rd_val (cur_a),
        .we     (we_a),
        .wr_idx (idx_a),
        .wr_val (nxt_a)
    );

    assign p0_ready   = ready_a[0];
    assign p1_ready   = ready_a[1];
    assign p0_presync = pre_a[0];
    assign p1_presync = pre_a[1];
    assign p0_err     = err_a[0];
    assign p1_err     = err_a[1];
endmodule

// File: rtl/sem_bank_exec_chk.sv
module sem_bank_exec_chk (
    input logic        clk,
    input logic        rst,
    input logic        p0_valid,
    input logic [31:0] p0_cmd,
    input logic        p0_ready,
    input logic        p0_err,
    input logic        p1_valid,
    input logic [31:0] p1_cmd,
    input logic        p1_ready
);
    // R2
    disabled_quick_chk: assert property (@(posedge clk) disable iff (rst)
        (p0_valid && !p0_cmd[31]) |-> p0_ready);

    // R3
    nop_quick_chk: assert property (@(posedge clk) disable iff (rst)
        (p0_valid && p0_cmd[31] && p0_cmd[26:24] == 3'd0) |-> p0_ready);

    // R6
    ge_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (p0_valid && p0_cmd[31] && p0_cmd[26:24] == 3'd5 && p0_cmd[11:0] == 12'd0) |-> p0_ready);

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        p0_err |-> (p0_valid && p0_ready && p0_cmd[31] && p0_cmd[26:24] == 3'd7));

    // R10
    port0_first_chk: assert property (@(posedge clk) disable iff (rst)
        (p0_valid && p0_ready && p0_cmd[31] && p1_valid && p1_cmd[31]
         && p0_cmd[20:16] == p1_cmd[20:16]) |-> !p1_ready);
endmodule

bind sem_bank_exec sem_bank_exec_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .p0_valid (p0_valid),
    .p0_cmd   (p0_cmd),
    .p0_ready (p0_ready),
    .p0_err   (p0_err),
    .p1_valid (p1_valid),
    .p1_cmd   (p1_cmd),
    .p1_ready (p1_ready)
);

// File: tb/tb_sem_bank_exec.sv
`timescale 1ns/1ps
module tb_sem_bank_exec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        p0_valid = 1'b0, p1_valid = 1'b0;
    logic [31:0] p0_cmd = '0, p1_cmd = '0;
    logic        p0_ready, p0_presync, p0_err, p1_ready, p1_presync, p1_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        logic  err;
        logic  pre;
        string tag;
    } exp_t;
    exp_t q0[$];
    exp_t q1[$];

    sem_bank_exec dut (
        .clk(clk), .rst(rst),
        .p0_valid(p0_valid), .p0_cmd(p0_cmd), .p0_ready(p0_ready),
        .p0_presync(p0_presync), .p0_err(p0_err),
        .p1_valid(p1_valid), .p1_cmd(p1_cmd), .p1_ready(p1_ready),
        .p1_presync(p1_presync), .p1_err(p1_err)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mk(bit en, logic [2:0] op, bit pre, logic [4:0] idx, logic [11:0] v);
        logic [31:0] w = '0;
        w[31] = en; w[26:24] = op; w[22] = pre; w[20:16] = idx; w[11:0] = v;
        return w;
    endfunction

    task automatic fail(input string msg);
        errors++;
        $display("FAIL %s", msg);
    endtask

    task automatic compare(input int p, input logic err, input logic pre);
        exp_t e;
        if ((p == 0 ? q0.size() : q1.size()) == 0) begin
            checks++;
            fail($sformatf("port%0d unexpected accept: actual accepted, expected stalled", p));
        end else begin
            e = (p == 0) ? q0.pop_front() : q1.pop_front();
            checks++;
            if (err !== e.err || pre !== e.pre)
                fail($sformatf("%s port%0d: actual err=%b pre=%b, expected err=%b pre=%b",
                               e.tag, p, err, pre, e.err, e.pre));
        end
    endtask

    always @(negedge clk) begin
        if (!rst && p0_valid && p0_ready) compare(0, p0_err, p0_presync);
        if (!rst && p1_valid && p1_ready) compare(1, p1_err, p1_presync);
    end

    task automatic send(input int p, input logic [31:0] w, input int maxw, input logic eerr,
                        input string tag, output int acc);
        exp_t e;
        bit got = 0;
        e.err = eerr; e.pre = w[31] & w[22]; e.tag = tag;
        acc = -1;
        @(posedge clk); #1;
        if (p == 0) begin q0.push_back(e); p0_valid = 1; p0_cmd = w; end
        else        begin q1.push_back(e); p1_valid = 1; p1_cmd = w; end
        for (int k = 0; k < maxw && !got; k++) begin
            @(negedge clk);
            if ((p == 0) ? p0_ready : p1_ready) begin got = 1; acc = cyc; end
        end
        @(posedge clk); #1;
        if (p == 0) p0_valid = 0; else p1_valid = 0;
        checks++;
        if (!got) begin
            fail($sformatf("%s: actual ready=0 for %0d cycles, expected accept", tag, maxw));
            if (p == 0) void'(q0.pop_back()); else void'(q1.pop_back());
        end
    endtask

    task automatic probe(input logic [4:0] idx, input logic [11:0] v, input string tag);
        int a;
        send(0, mk(1, 3'd4, 0, idx, v), 1, 0, $sformatf("%s sem[%0d]==%0d", tag, idx, v), a);
    endtask

    task automatic expect_stall(input int p, input logic [31:0] w, input int n, input string tag);
        @(posedge clk); #1;
        if (p == 0) begin p0_valid = 1; p0_cmd = w; end else begin p1_valid = 1; p1_cmd = w; end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            checks++;
            if ((p == 0) ? p0_ready : p1_ready)
                fail($sformatf("%s: actual ready=1, expected 0", tag));
        end
        @(posedge clk); #1;
        if (p == 0) p0_valid = 0; else p1_valid = 0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual still running, expected finished");
        finish_run();
    end

    initial begin
        int a0, a1, t;
        repeat (3) @(posedge clk); #1;
        rst = 0;

        // R1: reset state
        probe(0, 0, "R1"); probe(5, 0, "R1"); probe(31, 0, "R1");

        // R3: load, increment, decrement, no-op
        send(0, mk(1, 3'd1, 0, 3, 100), 1, 0, "R3 load", t); probe(3, 100, "R3");
        send(0, mk(1, 3'd2, 0, 3, 0), 1, 0, "R3 inc", t);    probe(3, 101, "R3");
        send(0, mk(1, 3'd3, 0, 3, 0), 1, 0, "R3 dec", t);    probe(3, 100, "R3");
        send(0, mk(1, 3'd0, 0, 3, 55), 1, 0, "R3 nop", t);   probe(3, 100, "R3");
        send(1, mk(1, 3'd1, 0, 31, 77), 1, 0, "R3 load p1", t); probe(31, 77, "R3");

        // R4: wrap both ways
        send(0, mk(1, 3'd1, 0, 4, 4095), 1, 0, "R4 load", t);
        send(0, mk(1, 3'd2, 0, 4, 0), 1, 0, "R4 inc", t); probe(4, 0, "R4");
        send(0, mk(1, 3'd3, 0, 4, 0), 1, 0, "R4 dec", t); probe(4, 4095, "R4");

        // R2: disabled command
        send(0, mk(0, 3'd1, 1, 3, 7), 1, 0, "R2 disabled", t); probe(3, 100, "R2");

        // R8: reserved opcode
        send(0, mk(1, 3'd7, 0, 3, 9), 1, 1, "R8 reserved", t); probe(3, 100, "R8");
        send(1, mk(1, 3'd7, 0, 3, 9), 1, 1, "R8 reserved p1", t); probe(3, 100, "R8");

        // R9: presync marker
        send(0, mk(1, 3'd1, 1, 6, 1), 1, 0, "R9 presync p0", t);
        send(1, mk(1, 3'd2, 1, 6, 0), 1, 0, "R9 presync p1", t); probe(6, 2, "R9");

        // R5 / R11: wait-equal released by the other port
        fork
            send(0, mk(1, 3'd4, 0, 8, 3), 40, 0, "R5 wait-eq", a0);
            begin
                repeat (3) @(posedge clk);
                for (int k = 0; k < 3; k++) send(1, mk(1, 3'd2, 0, 8, 0), 4, 0, "R11 inc", a1);
            end
        join
        checks++;
        if (!(a0 > a1)) fail($sformatf("R5/R11 wait-eq accept: actual cycle %0d, expected after %0d", a0, a1));
        probe(8, 3, "R5");

        // R6: wait-greater-or-equal
        send(0, mk(1, 3'd1, 0, 9, 5), 1, 0, "R6 load", t);
        expect_stall(0, mk(1, 3'd5, 0, 9, 6), 3, "R6 ge 6 on 5");
        send(0, mk(1, 3'd5, 0, 9, 5), 1, 0, "R6 ge 5 on 5", t);
        fork
            send(0, mk(1, 3'd5, 0, 9, 6), 30, 0, "R6 ge 6", a0);
            begin repeat (2) @(posedge clk); send(1, mk(1, 3'd2, 0, 9, 0), 4, 0, "R11 inc", a1); end
        join
        checks++;
        if (!(a0 > a1)) fail($sformatf("R6 ge accept: actual cycle %0d, expected after %0d", a0, a1));
        probe(9, 6, "R6");

        // R7: take
        expect_stall(0, mk(1, 3'd6, 0, 10, 0), 3, "R7 take on zero");
        send(0, mk(1, 3'd1, 0, 10, 2), 1, 0, "R7 load", t);
        send(0, mk(1, 3'd6, 0, 10, 0), 1, 0, "R7 take", t); probe(10, 1, "R7");
        send(0, mk(1, 3'd6, 0, 10, 0), 1, 0, "R7 take", t); probe(10, 0, "R7");
        expect_stall(1, mk(1, 3'd6, 0, 10, 0), 2, "R7 take on zero p1");
        fork
            send(1, mk(1, 3'd6, 0, 10, 0), 30, 0, "R7 take p1", a1);
            begin repeat (2) @(posedge clk); send(0, mk(1, 3'd2, 0, 10, 0), 2, 0, "R11 inc", a0); end
        join
        checks++;
        if (!(a1 > a0)) fail($sformatf("R7/R11 take accept: actual cycle %0d, expected after %0d", a1, a0));
        probe(10, 0, "R7");

        // R10: same index, port 0 first
        fork
            send(0, mk(1, 3'd2, 0, 12, 0), 1, 0, "R10 inc p0", a0);
            send(1, mk(1, 3'd2, 0, 12, 0), 3, 0, "R10 inc p1", a1);
        join
        checks++;
        if (a1 != a0 + 1) fail($sformatf("R10 p1 accept: actual cycle %0d, expected %0d", a1, a0 + 1));
        probe(12, 2, "R10");
        fork
            send(0, mk(1, 3'd1, 0, 13, 7), 1, 0, "R10 load p0", a0);
            send(1, mk(1, 3'd1, 0, 14, 9), 1, 0, "R10 load p1", a1);
        join
        checks++;
        if (a0 != a1) fail($sformatf("R10 parallel: actual cycles %0d/%0d, expected equal", a0, a1));
        probe(13, 7, "R10"); probe(14, 9, "R10");

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule